// File: doc/BRIEF.md
# Single-Pulse Window Checker

This block is a synthesizable runtime monitor for a pair of synchronous signals: an enable and a monitored line. When the enable is seen going from 0 to 1, the block opens an observation window of a fixed number of cycles. It then checks two things over that window. The enable must stay high throughout. The monitored line must make exactly one complete pulse, meaning one rise followed by one fall, with both edges inside the window.

The block reports each verdict with a single-cycle pass strobe or a single-cycle fail strobe. A fail comes with a reason code. Pulses are counted, not matched. A second rise after a completed pulse is an error even when that second pulse looks just like the first. A looser "contains at least one pulse" check would let it through.

The window length is a parameter. Edges of the monitored line are found by comparing it with its value in the previous cycle. Both inputs are assumed to be synchronous to the clock already. A verdict is registered and appears right after the clock edge that samples the deciding window cycle.

Top module: `pulse_window_checker`

## Requirements
- R1: While reset is high, and right after the clock edge at which it is sampled high, passStb and failStb are 0 and failReason is 0. A window that was in progress is discarded without a verdict.
- R2: A window opens on a cycle where enIn is 1 and was 0 in the previous cycle. The start cycle itself gives no verdict. The window is the WIN_LEN cycles that follow the start cycle. No verdict is given while no window is open.
- R3: If enIn is 0 in any window cycle, failStb fires with failReason = 1 (enable dropped) for that cycle, and the window is abandoned.
- R4: A rise of monIn is a cycle with monIn = 1 that follows a cycle with monIn = 0, and the start cycle counts as the previous cycle for the first window cycle. A fall is the reverse. When exactly one rise is followed by a fall inside the window, passStb fires for the last window cycle.
- R5: A rise of monIn in a window cycle after an earlier rise in the same window gives failStb with failReason = 4 (extra pulse) for that cycle, and the window is abandoned.
- R6: If no rise of monIn occurs in the window, failStb fires with failReason = 2 (no pulse) for the last window cycle.
- R7: If a rise occurred but no following fall by the last window cycle, failStb fires with failReason = 3 (incomplete pulse) for the last window cycle.
- R8: A fall of monIn that comes before any rise in the window (the line was already high at the start) has no effect on the verdict.
- R9: passStb and failStb are never high together and each lasts one cycle. failReason is 0 whenever failStb is 0 and is in the range 1 to 4 whenever failStb is 1.
- R10: Windows do not overlap. After a verdict, enIn staying high opens no new window. A new window needs enIn to go to 0 and then back to 1.
- R11: When enIn is 0 and monIn makes an extra rise in the same window cycle, the reason reported is 1 (enable dropped).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enIn | input | 1 | Enable; its rise opens a window |
| monIn | input | 1 | Monitored line whose pulses are counted |
| passStb | output | 1 | One-cycle strobe: window held exactly one pulse |
| failStb | output | 1 | One-cycle strobe: window failed |
| failReason | output | 3 | 0 none, 1 enable dropped, 2 no pulse, 3 incomplete pulse, 4 extra pulse |

## Verification
The bench runs a small window of four cycles. It sweeps every monitored-line pattern over the start cycle and the window, combined with an enable drop at every window position or no drop. For each cycle it predicts the verdict and compares it with the outputs. That sweep exposes a design that matches only the first pulse, since it would pass the double-pulse patterns. It also exposes a design that counts a fall seen before any rise, which would pass windows where the line only returns high, and one that reports extra or early verdicts off the last cycle. Directed runs at the default length repeat the single-pulse and double-pulse waveforms. Further runs hold the enable high past a verdict to show that a design that re-arms without a low enable would emit spurious strobes, and reset a window mid-flight to show that a stale verdict is not leaked.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [2:0] {
    RSN_NONE       = 3'd0,
    RSN_EN_DROP    = 3'd1,
    RSN_NO_PULSE   = 3'd2,
    RSN_OPEN_PULSE = 3'd3,
    RSN_EXTRA      = 3'd4
  } reason_e;

  typedef enum logic {
    ST_IDLE,
    ST_WATCH
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    openWin;
    logic    stepWin;
    logic    noteRise;
    logic    noteFall;
    logic    emitPass;
    logic    emitFail;
    reason_e failCode;
  } ctrl_s;

  // observations from datapath to control
  typedef struct packed {
    logic enNow;
    logic enRise;
    logic monRise;
    logic monFall;
    logic riseSeen;
    logic fallSeen;
    logic lastCycle;
  } stat_s;

endpackage

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int WIN_LEN = 10
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    enIn,
  input  logic    monIn,
  input  ctrl_s   ctrl,
  output stat_s   stat,
  output logic    passQ,
  output logic    failQ,
  output reason_e reasonQ
);

  localparam int CW = $clog2(WIN_LEN + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIN_LEN - 1);

  logic          enPrev;
  logic          monPrev;
  logic [CW-1:0] winCnt;
  logic          riseSeen;
  logic          fallSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      enPrev   <= 1'b0;
      monPrev  <= 1'b0;
      winCnt   <= '0;
      riseSeen <= 1'b0;
      fallSeen <= 1'b0;
      passQ    <= 1'b0;
      failQ    <= 1'b0;
      reasonQ  <= RSN_NONE;
    end else begin
      enPrev  <= enIn;
      monPrev <= monIn;
      passQ   <= ctrl.emitPass;
      failQ   <= ctrl.emitFail;
      reasonQ <= ctrl.emitFail ? ctrl.failCode : RSN_NONE;
      if (ctrl.openWin) begin
        winCnt   <= '0;
        riseSeen <= 1'b0;
        fallSeen <= 1'b0;
      end else begin
        if (ctrl.stepWin)  winCnt   <= winCnt + CW'(1);
        if (ctrl.noteRise) riseSeen <= 1'b1;
        if (ctrl.noteFall) fallSeen <= 1'b1;
      end
    end
  end

  always_comb begin
    stat.enNow     = enIn;
    stat.enRise    = enIn & ~enPrev;
    stat.monRise   = monIn & ~monPrev;
    stat.monFall   = ~monIn & monPrev;
    stat.riseSeen  = riseSeen;
    stat.fallSeen  = fallSeen;
    stat.lastCycle = (winCnt == LAST_IDX);
  end

endmodule

// File: rtl/pwc_control.sv
module pwc_control
  import pwc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  stat_s stat,
  output ctrl_s ctrl
);

  state_e state, stateNext;
  logic   pulseDone;
  logic   pulseBegun;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    pulseDone  = stat.fallSeen | (stat.monFall & stat.riseSeen);
    pulseBegun = stat.riseSeen | stat.monRise;
    ctrl       = '{default: '0, failCode: RSN_NONE};
    stateNext  = state;
    unique case (state)
      ST_IDLE: begin
        if (stat.enRise) begin
          ctrl.openWin = 1'b1;
          stateNext    = ST_WATCH;
        end
      end
      ST_WATCH: begin
        if (!stat.enNow) begin
          ctrl.emitFail = 1'b1;
          ctrl.failCode = RSN_EN_DROP;
          stateNext     = ST_IDLE;
        end else if (stat.monRise && stat.riseSeen) begin
          ctrl.emitFail = 1'b1;
          ctrl.failCode = RSN_EXTRA;
          stateNext     = ST_IDLE;
        end else begin
          ctrl.noteRise = stat.monRise;
          ctrl.noteFall = stat.monFall & stat.riseSeen;
          if (stat.lastCycle) begin
            stateNext = ST_IDLE;
            if (pulseDone) begin
              ctrl.emitPass = 1'b1;
            end else begin
              ctrl.emitFail = 1'b1;
              ctrl.failCode = pulseBegun ? RSN_OPEN_PULSE : RSN_NO_PULSE;
            end
          end else begin
            ctrl.stepWin = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pulse_window_checker.sv
module pulse_window_checker
  import pwc_pkg::*;
#(
  parameter int WIN_LEN = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enIn,
  input  logic       monIn,
  output logic       passStb,
  output logic       failStb,
  output logic [2:0] failReason
);

  ctrl_s   ctrl;
  stat_s   stat;
  reason_e reasonQ;

  pwc_control u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .stat (stat),
    .ctrl (ctrl)
  );

  pwc_datapath #(.WIN_LEN(WIN_LEN)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .enIn    (enIn),
    .monIn   (monIn),
    .ctrl    (ctrl),
    .stat    (stat),
    .passQ   (passStb),
    .failQ   (failStb),
    .reasonQ (reasonQ)
  );

  assign failReason = reasonQ;

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker (
  input logic       clk,
  input logic       rst,
  input logic       enIn,
  input logic       monIn,
  input logic       passStb,
  input logic       failStb,
  input logic [2:0] failReason
);

  assert_one_verdict_R9: assert property (@(posedge clk) disable iff (rst)
    !(passStb && failStb));

  assert_reason_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !failStb |-> failReason == 3'd0);

  assert_reason_range_R9: assert property (@(posedge clk) disable iff (rst)
    failStb |-> (failReason != 3'd0 && failReason <= 3'd4));

  assert_pass_short_R9: assert property (@(posedge clk) disable iff (rst)
    passStb |=> !passStb);

  assert_fail_short_R9: assert property (@(posedge clk) disable iff (rst)
    failStb |=> !failStb);

  assert_drop_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (failStb && failReason == 3'd1) |-> !$past(enIn));

  assert_pass_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    passStb |-> $past(enIn));

  assert_extra_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (failStb && failReason == 3'd4) |-> ($past(monIn) && !$past(monIn, 2) && $past(enIn)));

endmodule

bind pulse_window_checker pwc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .enIn       (enIn),
  .monIn      (monIn),
  .passStb    (passStb),
  .failStb    (failStb),
  .failReason (failReason)
);

// File: tb/test_pulse_window_checker.sv
`timescale 1ns/1ps
module test_pulse_window_checker;

  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       mon = 1'b0;
  logic       pS, fS, dP, dF;
  logic [2:0] rs, dR;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  pulse_window_checker #(.WIN_LEN(N)) i_pulse_window_checker (
    .clk(clk), .rst(rst), .enIn(en), .monIn(mon),
    .passStb(pS), .failStb(fS), .failReason(rs));

  pulse_window_checker i_pulse_window_checker_dflt (
    .clk(clk), .rst(rst), .enIn(en), .monIn(mon),
    .passStb(dP), .failStb(dF), .failReason(dR));

  task automatic step(input bit r, input bit e, input bit m);
    @(negedge clk);
    rst = r; en = e; mon = m;
    @(posedge clk);
    #1;
  endtask

  // value packing: pass*16 + fail*8 + reason
  task automatic expectOut(input bit useDflt, input int eP, input int eF,
                           input int eR, input string tag);
    int act, exp;
    act = useDflt ? (int'(dP) * 16 + int'(dF) * 8 + int'(dR))
                  : (int'(pS) * 16 + int'(fS) * 8 + int'(rs));
    exp = eP * 16 + eF * 8 + eR;
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (pass*16+fail*8+reason)", tag, act, exp);
    end
  endtask

  // one window on the small instance; bits[k] is mon in window cycle k (0 = start)
  task automatic runWindow(input int bits, input int dropAt);
    bit rS, fSn, done, mp, m, e, rise, fall;
    string tag;
    step(0, 0, 0); expectOut(0, 0, 0, 0, "R2");
    step(0, 1, bits[0]); expectOut(0, 0, 0, 0, "R2");
    rS = 0; fSn = 0; done = 0; mp = bits[0];
    for (int k = 1; k <= N; k++) begin
      if (!done) begin
        e = (k != dropAt);
        m = bits[k];
        step(0, e, m);
        rise = m && !mp;
        fall = !m && mp;
        if (!e) begin
          tag = (rise && rS) ? "R11" : "R3";
          expectOut(0, 0, 1, 1, tag);
          done = 1;
        end else if (rise && rS) begin
          expectOut(0, 0, 1, 4, "R5");
          done = 1;
        end else begin
          if (fall && rS) fSn = 1;
          if (rise) rS = 1;
          if (k == N) begin
            if (fSn)      expectOut(0, 1, 0, 0, bits[0] ? "R8" : "R4");
            else if (rS)  expectOut(0, 0, 1, 3, "R7");
            else          expectOut(0, 0, 1, 2, bits[0] ? "R8" : "R6");
            done = 1;
          end else begin
            expectOut(0, 0, 0, 0, "R2");
          end
        end
        mp = m;
      end
    end
    step(0, 0, 0); expectOut(0, 0, 0, 0, "R9");
  endtask

  initial begin
    // R1: reset state
    step(1, 0, 0); expectOut(0, 0, 0, 0, "R1");
    step(1, 1, 1); expectOut(0, 0, 0, 0, "R1");
    step(1, 0, 0); expectOut(0, 0, 0, 0, "R1");
    expectOut(1, 0, 0, 0, "R1");
    step(0, 0, 0); expectOut(0, 0, 0, 0, "R1");

    // near-exhaustive sweep of the small window
    for (int d = 0; d <= N; d++)
      for (int b = 0; b < (1 << (N + 1)); b++)
        runWindow(b, d);

    // R10: verdict, then enable held high opens nothing
    step(0, 0, 0);
    step(0, 1, 0);
    step(0, 1, 1); expectOut(0, 0, 0, 0, "R10");
    step(0, 1, 0); expectOut(0, 0, 0, 0, "R10");
    step(0, 1, 0); expectOut(0, 0, 0, 0, "R10");
    step(0, 1, 0); expectOut(0, 1, 0, 0, "R10");
    for (int i = 0; i < 6; i++) begin
      step(0, 1, i[0]); expectOut(0, 0, 0, 0, "R10");
    end
    step(0, 0, 0); expectOut(0, 0, 0, 0, "R10");
    step(0, 1, 0); expectOut(0, 0, 0, 0, "R10");
    step(0, 1, 1); expectOut(0, 0, 0, 0, "R10");
    step(0, 1, 0); expectOut(0, 0, 0, 0, "R10");
    step(0, 1, 0); expectOut(0, 0, 0, 0, "R10");
    step(0, 1, 0); expectOut(0, 1, 0, 0, "R10");

    // R1: reset mid-window discards the window
    step(0, 0, 0);
    step(0, 1, 0);
    step(0, 1, 1);
    step(1, 0, 0); expectOut(0, 0, 0, 0, "R1");
    step(0, 0, 0); expectOut(0, 0, 0, 0, "R1");
    step(0, 0, 0); expectOut(0, 0, 0, 0, "R1");

    // default length: single pulse passes, double pulse fails
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      step(0, i >= 3, (i >= 5 && i <= 11));
      if (i == 13) expectOut(1, 1, 0, 0, "R4");
      else         expectOut(1, 0, 0, 0, "R4");
    end
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      step(0, i >= 3, ((i >= 5 && i <= 6) || (i >= 9 && i <= 11)));
      if (i == 9) expectOut(1, 0, 1, 4, "R5");
      else        expectOut(1, 0, 0, 0, "R5");
    end
    step(0, 0, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule